// File: doc/BRIEF.md
# Watchdog Timer with Fixed Divider and Programmable Prescaler

This block is the watchdog of a small microcontroller core. It counts ticks from one of two sources: a free-running watchdog oscillator tick, or the instruction clock, which is the system clock divided by four. A static configuration input picks the source. Each source tick first passes through a fixed 256-step binary divider. The divider's carry then drives a prescaler whose ratio, 1:1 up to 1:128, comes from a three-bit select field. When the whole chain overflows, the block emits a one-cycle pulse and starts counting again from zero. Software keeps the pulse from arriving by issuing a clear strobe before the chain fills.

All logic runs on one fast clock. Both sources come in as single-cycle enables: a system-clock enable, from which the block derives the instruction clock, and an oscillator tick. The surrounding power controller drives a halt indication. While halted, the system clock is stopped, so the instruction source makes no progress, but the oscillator source keeps counting. An overflow during halt is reported on a separate wake output, so outside logic can tell a wake-up from a reset request. A static enable turns the whole block off.

Top module: `wdt_top`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, both `tmo_o` and `wake_o` are low, and the count chain starts from zero.
- R2: With `src_sel_i` = 0, each cycle with `osc_tick_i` = 1 counts one tick, and `sys_en_i` has no effect.
- R3: With `src_sel_i` = 1, one tick is counted on every fourth cycle with `sys_en_i` = 1 (and `halt_i` = 0), counted from reset. `osc_tick_i` has no effect.
- R4: With the select field `ws_i` = N, a pulse is produced after exactly 256·2^N counted ticks since the last restart.
- R5: `ws_i` = 3'b111 gives the longest period, 32768 ticks (256 × 128).
- R6: Each overflow produces a pulse exactly one cycle wide, in the cycle after the terminal tick's clock edge. Counting restarts from zero, so a steady tick stream gives evenly spaced pulses.
- R7: A cycle with `clr_i` = 1 resets the chain to zero, and a tick in that same cycle is not counted. The next pulse comes 256·2^N ticks after the clear, and no pulse appears in the cycle after a clear.
- R8: With `wdt_en_i` = 0, neither output ever pulses, whatever the ticks, clears or select values.
- R9: With the oscillator source, counting goes on during `halt_i` = 1. An overflow while halted raises `wake_o`, not `tmo_o`, and an overflow while not halted raises `tmo_o`, not `wake_o`.
- R10: With the instruction source, no tick is counted while `halt_i` = 1, even if `sys_en_i` pulses. After the halt ends, counting resumes from the preserved count.
- R11: Raising `ws_i` in the middle of a count keeps the accumulated count. The pulse then arrives once the total since restart reaches 256·2^N for the new N.
- R12: `tmo_o` and `wake_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| wdt_en_i | input | 1 | Static enable; 0 turns the watchdog off |
| src_sel_i | input | 1 | Static source select: 0 oscillator tick, 1 instruction clock |
| sys_en_i | input | 1 | System-clock enable, one cycle per system clock period |
| osc_tick_i | input | 1 | Watchdog oscillator tick, one cycle wide |
| halt_i | input | 1 | Core is halted; system clock is stopped |
| ws_i | input | 3 | Prescaler select; ratio is 2^ws_i |
| clr_i | input | 1 | Clear strobe; restarts the count chain |
| tmo_o | output | 1 | Registered one-cycle timeout pulse in normal mode |
| wake_o | output | 1 | Registered one-cycle timeout pulse while halted |

## Verification
If the fixed divider or the prescaler holds a wrong count, the error shows at the ports as a pulse that comes early, comes late or never comes. A wrong value in the instruction-phase counter shifts the pulse by up to three system-clock enables. The bench fixes the exact cycle of every expected pulse, so such a fault shows at the first expected overflow, within 256·2^N ticks of the last restart. A clear or halt gating fault shows as an extra pulse or a pulse on the wrong output. The bench catches it the cycle after the terminal tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_DIV_BITS    = 8;
  localparam int unsigned WDT_PRE_BITS    = 7;
  localparam int unsigned WDT_SEL_W       = 3;
  localparam int unsigned WDT_INSTR_DIV_W = 2;

  typedef enum logic {
    SRC_OSC   = 1'b0,
    SRC_INSTR = 1'b1
  } wdt_src_e;
endpackage

// File: rtl/wdt_src_sel.sv
module wdt_src_sel #(
  parameter int unsigned INSTR_DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic src_sel_i,
  input  logic sys_en_i,
  input  logic osc_tick_i,
  input  logic halt_i,
  output logic tick_o
);
  import wdt_pkg::*;

  logic [INSTR_DIV_W-1:0] phase_q;
  logic                   sys_run;
  logic                   instr_tick;

  // System clock is stopped while halted
  assign sys_run    = sys_en_i && !halt_i;
  assign instr_tick = sys_run && (&phase_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      phase_q <= '0;
    end else if (sys_run) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_comb begin
    if (!en_i) begin
      tick_o = 1'b0;
    end else if (src_sel_i == SRC_INSTR) begin
      tick_o = instr_tick;
    end else begin
      tick_o = osc_tick_i;
    end
  end
endmodule

// File: rtl/wdt_fixed_div.sv
module wdt_fixed_div #(
  parameter int unsigned DIV_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic carry_o
);
  logic [DIV_BITS-1:0] cnt_q;

  // Clear wins over a tick in the same cycle
  assign carry_o = en_i && !clr_i && tick_i && (&cnt_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i || clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRE_BITS = 7,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovf_o
);
  logic [PRE_BITS-1:0] cnt_q;
  logic [PRE_BITS-1:0] mask;
  logic                term;

  // Low sel_i bits of the mask are ones; ratio is 2^sel_i
  for (genvar g = 0; g < PRE_BITS; g++) begin : g_mask
    assign mask[g] = (32'(g) < 32'(sel_i));
  end

  assign term  = ((cnt_q & mask) == mask);
  assign ovf_o = en_i && !clr_i && step_i && term;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i || clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (term) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int unsigned DIV_BITS    = wdt_pkg::WDT_DIV_BITS,
  parameter int unsigned PRE_BITS    = wdt_pkg::WDT_PRE_BITS,
  parameter int unsigned SEL_W       = wdt_pkg::WDT_SEL_W,
  parameter int unsigned INSTR_DIV_W = wdt_pkg::WDT_INSTR_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wdt_en_i,
  input  logic             src_sel_i,
  input  logic             sys_en_i,
  input  logic             osc_tick_i,
  input  logic             halt_i,
  input  logic [SEL_W-1:0] ws_i,
  input  logic             clr_i,
  output logic             tmo_o,
  output logic             wake_o
);
  logic tick;
  logic carry;
  logic ovf;
  logic tmo_q;
  logic wake_q;

  wdt_src_sel #(
    .INSTR_DIV_W(INSTR_DIV_W)
  ) u_src (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (wdt_en_i),
    .src_sel_i (src_sel_i),
    .sys_en_i  (sys_en_i),
    .osc_tick_i(osc_tick_i),
    .halt_i    (halt_i),
    .tick_o    (tick)
  );

  wdt_fixed_div #(
    .DIV_BITS(DIV_BITS)
  ) u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (wdt_en_i),
    .clr_i  (clr_i),
    .tick_i (tick),
    .carry_o(carry)
  );

  wdt_prescaler #(
    .PRE_BITS(PRE_BITS),
    .SEL_W   (SEL_W)
  ) u_pre (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (wdt_en_i),
    .clr_i (clr_i),
    .step_i(carry),
    .sel_i (ws_i),
    .ovf_o (ovf)
  );

  // Registered outputs; the halt state picks which one fires
  always_ff @(posedge clk_i) begin
    if (rst_i || !wdt_en_i) begin
      tmo_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      tmo_q  <= ovf && !halt_i;
      wake_q <= ovf && halt_i;
    end
  end

  assign tmo_o  = tmo_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wdt_en_i,
  input logic             src_sel_i,
  input logic             sys_en_i,
  input logic             osc_tick_i,
  input logic             halt_i,
  input logic [SEL_W-1:0] ws_i,
  input logic             clr_i,
  input logic             tmo_o,
  input logic             wake_o
);
  logic ws_seen;
  assign ws_seen = ^ws_i;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (tmo_o || wake_o) |=> (!tmo_o && !wake_o));

  assert_exclusive_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !(tmo_o && wake_o));

  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !wdt_en_i |=> (!tmo_o && !wake_o));

  assert_clear_no_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (!tmo_o && !wake_o));

  assert_wake_in_halt_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |-> $past(halt_i));

  assert_tmo_not_halt_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    tmo_o |-> !$past(halt_i));

  assert_osc_idle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!src_sel_i && !osc_tick_i) |=> (!tmo_o && !wake_o));

  assert_instr_stopped_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_sel_i && (halt_i || !sys_en_i || ws_seen === 1'bx)) |=> (!tmo_o && !wake_o));
endmodule

bind wdt_top wdt_checker #(.SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wdt_en_i  (wdt_en_i),
  .src_sel_i (src_sel_i),
  .sys_en_i  (sys_en_i),
  .osc_tick_i(osc_tick_i),
  .halt_i    (halt_i),
  .ws_i      (ws_i),
  .clr_i     (clr_i),
  .tmo_o     (tmo_o),
  .wake_o    (wake_o)
);

// File: tb/wdt_top_tb.sv
`timescale 1ns/1ps
module wdt_top_tb;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       wdt_en_i = 1'b1;
  logic       src_sel_i = 1'b0;
  logic       sys_en_i = 1'b0;
  logic       osc_tick_i = 1'b0;
  logic       halt_i = 1'b0;
  logic [2:0] ws_i = 3'd0;
  logic       clr_i = 1'b0;
  logic       tmo_o;
  logic       wake_o;

  typedef struct packed {
    logic        wake;
    int unsigned cyc;
  } exp_t;

  exp_t        exp_q[$];
  int unsigned cyc = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  int          pulses = 0;
  int unsigned mcnt = 0;
  int unsigned ph = 0;
  logic [2:0]  cur_ws = 3'd0;
  logic        cur_halt = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  wdt_top u_dut (
    .clk_i     (clk),
    .rst_i     (rst_i),
    .wdt_en_i  (wdt_en_i),
    .src_sel_i (src_sel_i),
    .sys_en_i  (sys_en_i),
    .osc_tick_i(osc_tick_i),
    .halt_i    (halt_i),
    .ws_i      (ws_i),
    .clr_i     (clr_i),
    .tmo_o     (tmo_o),
    .wake_o    (wake_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus plus the expected-pulse model
  task automatic step(input logic osc, input logic sen, input logic clr);
    logic tk;
    @(negedge clk);
    osc_tick_i = osc;
    sys_en_i   = sen;
    clr_i      = clr;
    ws_i       = cur_ws;
    halt_i     = cur_halt;
    tk = 1'b0;
    if (wdt_en_i) begin
      if (src_sel_i && sen && !cur_halt) begin
        tk = (ph == 3);
        ph = (ph + 1) % 4;
      end
      if (!src_sel_i) tk = osc;
      if (clr) begin
        mcnt = 0;
      end else if (tk) begin
        mcnt++;
        if (mcnt == (32'd256 << cur_ws)) begin
          exp_q.push_back('{wake: cur_halt, cyc: cyc + 1});
          mcnt = 0;
        end
      end
    end
  endtask

  task automatic do_reset(input logic en, input logic src);
    @(negedge clk);
    rst_i = 1'b1;
    wdt_en_i = en;
    src_sel_i = src;
    osc_tick_i = 1'b0;
    sys_en_i = 1'b0;
    clr_i = 1'b0;
    cur_halt = 1'b0;
    halt_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(tmo_o == 1'b0, "R1 tmo in reset", int'(tmo_o), 0);
    rst_i = 1'b0;
    mcnt = 0;
    ph = 0;
    @(negedge clk);
    chk(tmo_o == 1'b0 && wake_o == 1'b0, "R1 outputs after reset", int'({tmo_o, wake_o}), 0);
  endtask

  task automatic expect_drained(input string req, input int want_pulses, input int base);
    repeat (3) step(1'b0, 1'b0, 1'b0);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(pulses - base == want_pulses, req, pulses - base, want_pulses);
  endtask

  // Monitor: pops expected pulses and compares cycle and output
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst_i && (tmo_o || wake_o)) begin
        exp_t e;
        pulses++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R8 unexpected pulse", int'(cyc), -1);
        end else begin
          e = exp_q.pop_front();
          chk(e.cyc == cyc, "R4 pulse cycle", int'(cyc), int'(e.cyc));
          chk(wake_o == e.wake && tmo_o == !e.wake, "R9 pulse output", int'(wake_o), int'(e.wake));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int base;
    // R1, R2: oscillator source, ratio 1
    do_reset(1'b1, 1'b0);
    cur_ws = 3'd0;
    base = pulses;
    for (int i = 0; i < 768; i++) step(1'b1, 1'b1, 1'b0);
    expect_drained("R6 periodic at ratio 1", 3, base);

    // R4: ratio 8, ticks every other cycle
    base = pulses;
    cur_ws = 3'd3;
    for (int i = 0; i < 4096; i++) step(i[0], 1'b0, 1'b0);
    expect_drained("R4 ratio 8 sparse", 1, base);

    // R5: longest period
    base = pulses;
    cur_ws = 3'd7;
    for (int i = 0; i < 32768; i++) step(1'b1, 1'b0, 1'b0);
    expect_drained("R5 ratio 128", 1, base);

    // R4: ratio 2, ticks every third cycle
    base = pulses;
    cur_ws = 3'd1;
    for (int i = 0; i < 3072; i++) step((i % 3) == 0, 1'b0, 1'b0);
    expect_drained("R4 ratio 2 every third", 2, base);

    // R7: clear mid-count, with a tick in the clear cycle
    base = pulses;
    cur_ws = 3'd0;
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 1'b0);
    chk(pulses == base, "R7 no pulse before 256 after clear", pulses - base, 0);
    step(1'b1, 1'b0, 1'b0);
    expect_drained("R7 pulse after clear", 1, base);

    // R9: halted with oscillator source raises wake
    base = pulses;
    cur_halt = 1'b1;
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 1'b0);
    expect_drained("R9 wake in halt", 1, base);
    cur_halt = 1'b0;

    // R11: raise the select mid-count
    base = pulses;
    cur_ws = 3'd2;
    for (int i = 0; i < 512; i++) step(1'b1, 1'b0, 1'b0);
    cur_ws = 3'd3;
    for (int i = 0; i < 1536; i++) step(1'b1, 1'b0, 1'b0);
    expect_drained("R11 select change keeps count", 1, base);

    // R3, R10: instruction source
    do_reset(1'b1, 1'b1);
    base = pulses;
    cur_ws = 3'd0;
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b0);
    cur_halt = 1'b1;
    for (int i = 0; i < 2000; i++) step(1'b1, 1'b1, 1'b0);
    chk(pulses == base, "R10 no count in halt", pulses - base, 0);
    cur_halt = 1'b0;
    for (int i = 0; i < 1448; i++) step(1'b0, 1'b1, 1'b0);
    expect_drained("R3 instruction clock quarter rate", 2, base);

    // R8: disabled
    do_reset(1'b0, 1'b0);
    base = pulses;
    for (int i = 0; i < 1000; i++) step(1'b1, 1'b1, (i % 97) == 5);
    expect_drained("R8 disabled never pulses", 0, base);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule